// File: doc/BRIEF.md
# Masked Vector Blend Unit

This block assembles a 512-bit result vector one element at a time. For every element position it picks a value from one of two 512-bit source vectors, steered by one bit of a 16-bit select mask. Elements are either 32 or 64 bits wide. The active vector length is 128, 256 or 512 bits. Any result bits above the active length are forced to zero.

Three options change the per-element choice:

- **Broadcast:** the lowest element-sized slice of the second source replaces each selected element's own lane.
- **Zeroing:** elements whose mask bit is clear become zero instead of taking the first source.
- **Mask disable:** with the mask switched off, every active element takes the second source.

An input strobe launches one operation. The result and a one-cycle valid pulse appear on the next clock.

Top module: `masked_blend_unit`

## Requirements
- R1: With the mask enabled (`mask_on`=1), an active element whose mask bit is 1 takes the second-source element. An active element whose mask bit is 0 takes the first-source element when zeroing is off. Element j uses mask bit j.
- R2: With `zero_en`=1 and the mask enabled, every active element whose mask bit is 0 is all zeros.
- R3: With `mask_on`=0, every active element takes the second-source value, whatever the values of `sel_mask` and `zero_en`.
- R4: `elem_wide`=0 selects 32-bit elements: element j occupies bits [32j+31:32j]. `elem_wide`=1 selects 64-bit elements: element j occupies bits [64j+63:64j].
- R5: `vec_len` sets the active length as follows: code 0 is 128 bits, code 1 is 256 bits, and codes 2 and 3 are 512 bits. The element count is the active length divided by the element width.
- R6: With `bcast_en`=1, every element that would take the second source instead takes `src_b` bits [31:0] (32-bit elements) or bits [63:0] (64-bit elements).
- R7: All `out_data` bits at or above the active vector length are zero.
- R8: Mask bits at positions equal to or above the element count have no effect on `out_data`.
- R9: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `out_data` then holds that operation's result. `out_data` is unchanged after a cycle without `in_valid`.
- R10: A synchronous active-low reset (`rst_n`=0) clears `out_valid` and `out_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Launches one operation this cycle |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector / broadcast scalar in low bits |
| sel_mask | input | 16 | Per-element select mask |
| mask_on | input | 1 | 1: use `sel_mask`; 0: select second source everywhere |
| elem_wide | input | 1 | 0: 32-bit elements; 1: 64-bit elements |
| vec_len | input | 2 | Active length code: 0=128, 1=256, 2/3=512 |
| bcast_en | input | 1 | Broadcast lowest element of `src_b` |
| zero_en | input | 1 | Zero elements with mask bit 0 |
| out_valid | output | 1 | Result valid pulse |
| out_data | output | 512 | Registered blended result |

## Verification
Two pairs of functions can act in the same operation.

- **Broadcast with zeroing:** in one element, broadcast decides where the selected value comes from. In a neighbouring element, zeroing decides the same for an unselected value.
- **Upper-lane clearing with stale mask bits:** for short vector lengths, upper-lane clearing meets mask bits set above the element count.

The bench drives every combination of element size, length code (including code 3), broadcast, zeroing and mask enable. It uses dense masks and all-ones masks. Each full 512-bit result is compared with a reference loop built only from the requirements, so a lane that takes the wrong source is caught, as is an upper lane left uncleared.

// File: rtl/blend_pkg.sv
// blend_pkg: shared widths and length codes for the masked blend unit.
// Assumes the vector is built from WORD_W-bit words and a wide element
// spans exactly two words.
package blend_pkg;
    parameter int DATA_W    = 512;
    parameter int WORD_W    = 32;
    localparam int NUM_WORDS = DATA_W / WORD_W;
    localparam int MASK_W    = NUM_WORDS;
    localparam int CNT_W     = $clog2(NUM_WORDS) + 1;
    localparam int WORDS_MIN = 128 / WORD_W;

    typedef enum logic [1:0] {
        LEN_SHORT = 2'd0,
        LEN_MID   = 2'd1,
        LEN_FULL  = 2'd2,
        LEN_ALT   = 2'd3
    } len_code_e;

    // Number of active words for a length code (code 3 aliases full).
    function automatic logic [CNT_W-1:0] active_words(input logic [1:0] code);
        case (code)
            LEN_SHORT: active_words = CNT_W'(WORDS_MIN);
            LEN_MID:   active_words = CNT_W'(2 * WORDS_MIN);
            default:   active_words = CNT_W'(4 * WORDS_MIN);
        endcase
    endfunction
endpackage

// File: rtl/blend_word_ctl.sv
// blend_word_ctl: per-word steering decisions.
// For each word it produces three flags. word_act says the word lies
// inside the active length. pick_b says the word takes the second
// source. keep_a says the word takes the first source. A wide element
// drives both of its words from one mask bit. Purely combinational.
module blend_word_ctl
    import blend_pkg::*;
(
    input  logic [MASK_W-1:0]    sel_mask,
    input  logic                 mask_on,
    input  logic                 elem_wide,
    input  logic [1:0]           vec_len,
    input  logic                 zero_en,
    output logic [NUM_WORDS-1:0] word_act,
    output logic [NUM_WORDS-1:0] pick_b,
    output logic [NUM_WORDS-1:0] keep_a
);
    logic [CNT_W-1:0] act_cnt;

    // Decode the length code into a count of live words.
    always_comb begin
        act_cnt = active_words(vec_len);
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic mbit;
        logic chosen;

        // Fetch the mask bit owning this word for the current element size.
        always_comb begin
            mbit = elem_wide ? sel_mask[w/2] : sel_mask[w];
        end

        // Form this word's live, take-second and take-first flags.
        always_comb begin
            word_act[w] = CNT_W'(w) < act_cnt;
            chosen      = mask_on ? mbit : 1'b1;
            pick_b[w]   = word_act[w] & chosen;
            keep_a[w]   = word_act[w] & ~chosen & ~zero_en;
        end
    end
endmodule

// File: rtl/blend_word_mux.sv
// blend_word_mux: forms one WORD_W-bit word of the result.
// Assumes pick_b and keep_a are never both high. A word with neither
// flag set (inactive or zeroed) yields zero. ODD_LANE picks which half
// of a wide broadcast element this word carries.
module blend_word_mux #(
    parameter int WORD_W   = 32,
    parameter bit ODD_LANE = 1'b0
) (
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    input  logic [WORD_W-1:0] bc_even,
    input  logic [WORD_W-1:0] bc_odd,
    input  logic              bcast_en,
    input  logic              pick_b,
    input  logic              keep_a,
    output logic [WORD_W-1:0] res_word
);
    logic [WORD_W-1:0] b_eff;

    // Choose between the lane's own second-source word and the broadcast slice.
    always_comb begin
        if (bcast_en) b_eff = ODD_LANE ? bc_odd : bc_even;
        else          b_eff = b_word;
    end

    // Final three-way choice: second source, first source or zero.
    always_comb begin
        if (pick_b)      res_word = b_eff;
        else if (keep_a) res_word = a_word;
        else             res_word = '0;
    end
endmodule

// File: rtl/blend_out_reg.sv
// blend_out_reg: output stage for the blend result.
// Captures the result when launch is high and holds it otherwise.
// Valid is the launch strobe delayed by one cycle. Synchronous
// active-low reset clears both.
module blend_out_reg #(
    parameter int W = 512
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         launch,
    input  logic [W-1:0] next_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    // Register the valid pulse and capture data on launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= launch;
            if (launch) out_data <= next_data;
        end
    end

    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> out_valid);
    p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> !out_valid);
    p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> $stable(out_data));
endmodule

// File: rtl/masked_blend_unit.sv
// masked_blend_unit: top of the masked vector blend.
// Each result word comes from the first source, the second source, a
// broadcast slice of the second source, or zero. The choice depends on
// the mask, the element size, the vector length and the option flags.
// The result is registered once. Assumes 64-bit elements span two words.
module masked_blend_unit
    import blend_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [MASK_W-1:0] sel_mask,
    input  logic              mask_on,
    input  logic              elem_wide,
    input  logic [1:0]        vec_len,
    input  logic              bcast_en,
    input  logic              zero_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic [NUM_WORDS-1:0] word_act;
    logic [NUM_WORDS-1:0] pick_b;
    logic [NUM_WORDS-1:0] keep_a;
    logic [WORD_W-1:0]    bc_even;
    logic [WORD_W-1:0]    bc_odd;
    logic [DATA_W-1:0]    blended;

    // Broadcast slices: low word always, upper word only for wide elements.
    always_comb begin
        bc_even = src_b[WORD_W-1:0];
        bc_odd  = elem_wide ? src_b[2*WORD_W-1:WORD_W] : src_b[WORD_W-1:0];
    end

    blend_word_ctl u_ctl (
        .sel_mask  (sel_mask),
        .mask_on   (mask_on),
        .elem_wide (elem_wide),
        .vec_len   (vec_len),
        .zero_en   (zero_en),
        .word_act  (word_act),
        .pick_b    (pick_b),
        .keep_a    (keep_a)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_lane
        blend_word_mux #(
            .WORD_W   (WORD_W),
            .ODD_LANE (w % 2 == 1)
        ) u_mux (
            .a_word   (src_a[w*WORD_W +: WORD_W]),
            .b_word   (src_b[w*WORD_W +: WORD_W]),
            .bc_even  (bc_even),
            .bc_odd   (bc_odd),
            .bcast_en (bcast_en),
            .pick_b   (pick_b[w]),
            .keep_a   (keep_a[w]),
            .res_word (blended[w*WORD_W +: WORD_W])
        );
    end

    blend_out_reg #(.W(DATA_W)) u_oreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (in_valid),
        .next_data (blended),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Word 0 is always live: check select, zeroing, mask-off and broadcast there.
    p_select_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && mask_on && sel_mask[0] && !bcast_en
        |=> out_data[WORD_W-1:0] == $past(src_b[WORD_W-1:0]));
    p_select_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && mask_on && !sel_mask[0] && !zero_en
        |=> out_data[WORD_W-1:0] == $past(src_a[WORD_W-1:0]));
    p_zeroing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && mask_on && !sel_mask[0] && zero_en
        |=> out_data[WORD_W-1:0] == '0);
    p_nomask_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !mask_on && !bcast_en && vec_len[1]
        |=> out_data == $past(src_b));
    p_bcast_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !mask_on && bcast_en && !elem_wide && vec_len == 2'd0
        |=> out_data[4*WORD_W-1:0] == {4{$past(src_b[WORD_W-1:0])}});
    p_upper_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && vec_len == 2'd0
        |=> out_data[DATA_W-1:4*WORD_W] == '0);
endmodule

// File: tb/masked_blend_unit_tb.sv
`timescale 1ns/1ps
module masked_blend_unit_tb;
    localparam int DW = 512;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [DW-1:0] src_a, src_b;
    logic [15:0]   sel_mask;
    logic          mask_on, elem_wide, bcast_en, zero_en;
    logic [1:0]    vec_len;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    masked_blend_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .sel_mask(sel_mask),
        .mask_on(mask_on), .elem_wide(elem_wide), .vec_len(vec_len),
        .bcast_en(bcast_en), .zero_en(zero_en),
        .out_valid(out_valid), .out_data(out_data)
    );

    // Reference model written from the requirements alone.
    function automatic logic [DW-1:0] ref_blend(
        input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [15:0] m,
        input logic mon, input logic wide, input logic [1:0] vl,
        input logic bc, input logic z);
        logic [DW-1:0] r;
        int bits, ew, cnt;
        r    = '0;
        bits = (vl == 2'd0) ? 128 : (vl == 2'd1) ? 256 : 512;
        ew   = wide ? 64 : 32;
        cnt  = bits / ew;
        for (int e = 0; e < cnt; e++) begin
            logic take_b;
            take_b = mon ? m[e] : 1'b1;
            for (int k = 0; k < ew; k++) begin
                if (take_b)  r[e*ew + k] = bc ? b[k] : b[e*ew + k];
                else if (!z) r[e*ew + k] = a[e*ew + k];
                else         r[e*ew + k] = 1'b0;
            end
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] rand_vec();
        logic [DW-1:0] v;
        for (int i = 0; i < DW/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check_vec(input string tag, input logic [DW-1:0] act,
                             input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // One operation: drive at negedge, sample after the capturing edge.
    task automatic run_op(input string tag, input logic [DW-1:0] a,
        input logic [DW-1:0] b, input logic [15:0] m, input logic mon,
        input logic wide, input logic [1:0] vl, input logic bc, input logic z);
        logic [DW-1:0] exp;
        @(negedge clk);
        src_a = a; src_b = b; sel_mask = m; mask_on = mon;
        elem_wide = wide; vec_len = vl; bcast_en = bc; zero_en = z;
        in_valid = 1'b1;
        exp = ref_blend(a, b, m, mon, wide, vl, bc, z);
        @(posedge clk); #1;
        check_bit({tag, " R9 valid"}, out_valid, 1'b1);
        check_vec(tag, out_data, exp);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [DW-1:0] held, ra, rb;
        void'($urandom(32'h5eed_b1e0));
        rst_n = 1'b0; in_valid = 1'b0; src_a = '0; src_b = '0; sel_mask = '0;
        mask_on = 1'b0; elem_wide = 1'b0; vec_len = 2'd0; bcast_en = 1'b0;
        zero_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_bit("R10 reset valid", out_valid, 1'b0);
        check_vec("R10 reset data", out_data, '0);
        @(negedge clk); rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6 R7: every size/length/option combination.
        for (int wd = 0; wd < 2; wd++)
            for (int vl = 0; vl < 4; vl++)
                for (int opt = 0; opt < 8; opt++)
                    run_op("R1/R2/R3/R4/R5/R6/R7 sweep", rand_vec(), rand_vec(),
                           16'($urandom), opt[2], wd[0], 2'(vl), opt[0], opt[1]);

        // R8: mask bits above the element count must not matter.
        ra = rand_vec(); rb = rand_vec();
        run_op("R8 high bits narrow128", ra, rb, 16'hFFF0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
        run_op("R8 high bits wide256",  ra, rb, 16'hFFF0, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1);
        run_op("R8 high bits wide512",  ra, rb, 16'hFF00, 1'b1, 1'b1, 2'd2, 1'b1, 1'b0);
        // R6 with R2 in one op: broadcast selected lanes, zero the others.
        run_op("R6 bcast+zero", ra, rb, 16'hA5A5, 1'b1, 1'b0, 2'd3, 1'b1, 1'b1);
        run_op("R6 bcast wide", ra, rb, 16'h0055, 1'b1, 1'b1, 2'd2, 1'b1, 1'b0);
        // R3: mask off ignores both mask and zeroing flag.
        run_op("R3 mask off", ra, rb, 16'h0000, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1);
        // R1: all ones / all zeros masks.
        run_op("R1 all b", ra, rb, 16'hFFFF, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0);
        run_op("R1 all a", ra, rb, 16'h0000, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0);

        // R9: idle cycles leave valid low and data unchanged.
        held = out_data;
        @(posedge clk); #1;
        check_bit("R9 idle valid", out_valid, 1'b0);
        @(negedge clk); src_a = rand_vec(); src_b = rand_vec(); sel_mask = 16'h1234;
        @(posedge clk); #1;
        check_vec("R9 hold data", out_data, held);
        check_bit("R9 idle valid2", out_valid, 1'b0);

        // Random stream.
        for (int n = 0; n < 300; n++) begin
            logic [3:0] r;
            r = 4'($urandom);
            run_op("R1/R4/R5/R6 random", rand_vec(), rand_vec(), 16'($urandom),
                   r[0], r[1], 2'($urandom), r[2], r[3]);
        end

        // R10: reset mid-run clears outputs.
        run_op("pre-reset", rand_vec(), rand_vec(), 16'hFFFF, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check_bit("R10 mid reset valid", out_valid, 1'b0);
        check_vec("R10 mid reset data", out_data, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule